// File: doc/BRIEF.md
# Frame-Start Input Latch Generator

This block follows the receive-data-valid line of a frame receiver and, a fixed number of clock cycles after that line goes from low to high, raises a start-of-frame pulse of fixed width. A set number of cycles after the pulse begins, it registers a parallel digital input word. This lets the sampled inputs go out in the frame that is arriving. All delays are set in clock cycles by parameters. At 100 MHz a four-cycle pulse gives at least 40 ns of high time. A sampling point of up to 120 cycles keeps the capture inside the 1.2 µs window in which the inputs still reach the current frame.

Each accepted rising edge of the valid line is one input event. Events are kept a minimum number of cycles apart: 44 cycles gives 440 ns at 100 MHz. A rising edge is ignored when it comes too soon after the last accepted one, or while the sequence for an earlier frame is still waiting for its capture. An ignored edge produces no pulse, no capture and no change to the latched word. The parameters must satisfy SOF_DELAY >= 1, SOF_WIDTH >= 1, SOF_WIDTH <= SAMPLE_AT and SPACING >= 1.

Top module: `sof_input_latch`

## Requirements
- R1: While the synchronous active-high reset is high and in the first cycle after it, `sof` and `dout_valid` are 0 and `dout` is all zeros. The spacing timer leaves reset already expired.
- R2: When `rx_dv` is sampled high at a clock edge after being sampled low at the previous edge (reset counts as low), and that edge is accepted, `sof` becomes 1 after the edge that comes SOF_DELAY edges later.
- R3: Each `sof` pulse lasts exactly SOF_WIDTH clock cycles.
- R4: `dout` takes the value of `din` that is present at the clock edge SAMPLE_AT edges after the edge that raised `sof`. It updates at that edge.
- R5: `dout_valid` is high for exactly one cycle, in the cycle in which `dout` shows a new capture. Between captures `dout` holds its value.
- R6: A rising edge of `rx_dv` that comes fewer than SPACING edges after the previous accepted rising edge is ignored. It produces no `sof` and no capture, and `dout` keeps its value. An edge exactly SPACING edges later is accepted if no sequence is running.
- R7: A rising edge of `rx_dv` that comes while a sequence is running is ignored. This includes the capture edge itself. The next rising edge after the capture edge is accepted if the spacing has elapsed.
- R8: Only transitions of `rx_dv` from low to high count. Holding `rx_dv` high or letting it fall starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive-data-valid from the frame receiver |
| din | input | DATA_W | Parallel digital input word |
| sof | output | 1 | Start-of-frame pulse, SOF_WIDTH cycles |
| dout | output | DATA_W | Latched input word |
| dout_valid | output | 1 | One-cycle strobe marking a new capture |

## Verification
The capture for one frame and the rising edge of the next frame's valid line can land on the same clock edge. In that case the sequence ends and a new start is requested at once. A second instance uses a spacing shorter than its capture delay, so the spacing timer cannot hide this case. That instance raises `rx_dv` exactly on its capture edge and again two edges later. The check expects the capture to go through, the coinciding edge to give no pulse, and the later edge to start a full second pulse and capture.

// File: rtl/sil_pkg.sv
package sil_pkg;

  // Bits needed to hold values 0..max_val.
  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

endpackage

// File: rtl/sil_rise_detect.sv
module sil_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // A held-high level yields one rise only.
  assert_single_rise_R8: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sil_gap_timer.sv
module sil_gap_timer #(
  parameter int unsigned SPACING = 44
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ready_o
);
  import sil_pkg::*;

  localparam int unsigned GW = cnt_w(SPACING);
  localparam logic [GW-1:0] RELOAD = GW'(SPACING - 1);

  logic [GW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start_i)       remain <= RELOAD;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign ready_o = (remain == '0);

  // After an accepted event the timer cannot read expired next cycle unless SPACING is 1.
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (start_i && SPACING > 1) |=> !ready_o);

endmodule

// File: rtl/sil_sequencer.sv
module sil_sequencer #(
  parameter int unsigned SOF_DELAY = 2,
  parameter int unsigned SOF_WIDTH = 4,
  parameter int unsigned SAMPLE_AT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic sof_o,
  output logic take_o
);
  import sil_pkg::*;

  localparam int unsigned SPAN = SOF_DELAY + SAMPLE_AT;
  localparam int unsigned CW   = cnt_w(SPAN);
  localparam logic [CW-1:0] ON_AT   = CW'(SOF_DELAY);
  localparam logic [CW-1:0] OFF_AT  = CW'(SOF_DELAY + SOF_WIDTH);
  localparam logic [CW-1:0] TAKE_AT = CW'(SPAN);

  phase_t        phase;
  logic [CW-1:0] step;

  assign busy_o = (phase == PH_RUN);
  assign take_o = busy_o && (step == TAKE_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      step  <= '0;
      sof_o <= 1'b0;
    end else if (start_i) begin
      phase <= PH_RUN;
      step  <= CW'(1);
      sof_o <= 1'b0;
    end else if (busy_o) begin
      step  <= step + 1'b1;
      sof_o <= (step >= ON_AT) && (step < OFF_AT);
      if (take_o) phase <= PH_IDLE;
    end else begin
      sof_o <= 1'b0;
    end
  end

  // Pulse-width monitor.
  localparam int unsigned RW = cnt_w(SOF_WIDTH);
  localparam logic [RW-1:0] WIDTH_C = RW'(SOF_WIDTH);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)                             run_len <= '0;
    else if (!sof_o)                     run_len <= '0;
    else if (run_len != {RW{1'b1}})      run_len <= run_len + 1'b1;
  end

  assert_sof_not_long_R3: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> (run_len < WIDTH_C));

  assert_sof_not_short_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sof_o) |-> ($past(run_len) == WIDTH_C - 1'b1));

endmodule

// File: rtl/sil_capture.sv
module sil_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              strobe_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= take_i;
      if (take_i) dout <= din;
    end
  end

  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe_o |-> $stable(dout));

endmodule

// File: rtl/sof_input_latch.sv
module sof_input_latch #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SOF_DELAY = 2,
  parameter int unsigned SOF_WIDTH = 4,
  parameter int unsigned SAMPLE_AT = 100,
  parameter int unsigned SPACING   = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_dv,
  input  logic [DATA_W-1:0] din,
  output logic              sof,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  import sil_pkg::*;

  logic rise, gap_ready, busy, take, start;

  sil_rise_detect u_rise (
    .clk     (clk),
    .rst     (rst),
    .level_i (rx_dv),
    .rise_o  (rise)
  );

  sil_gap_timer #(.SPACING(SPACING)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .ready_o (gap_ready)
  );

  sil_sequencer #(
    .SOF_DELAY (SOF_DELAY),
    .SOF_WIDTH (SOF_WIDTH),
    .SAMPLE_AT (SAMPLE_AT)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .busy_o  (busy),
    .sof_o   (sof),
    .take_o  (take)
  );

  sil_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .take_i   (take),
    .din      (din),
    .dout     (dout),
    .strobe_o (dout_valid)
  );

  // An edge is accepted only when no sequence runs and the spacing has elapsed.
  assign start = rise & gap_ready & ~busy;

  // Port-level monitor: cycles since the last rise of sof.
  localparam int unsigned MON_MAX = SPACING + SAMPLE_AT + SOF_DELAY;
  localparam int unsigned MW      = cnt_w(MON_MAX);
  localparam logic [MW-1:0] SAMPLE_C  = MW'(SAMPLE_AT);
  localparam logic [MW-1:0] SPACING_C = MW'(SPACING);
  localparam logic [MW-1:0] MON_TOP   = MW'(MON_MAX);

  logic          sof_d, seen;
  logic [MW-1:0] since_sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      sof_d     <= 1'b0;
      seen      <= 1'b0;
      since_sof <= '0;
    end else begin
      sof_d <= sof;
      if (sof && !sof_d) begin
        seen      <= 1'b1;
        since_sof <= MW'(1);
      end else if (since_sof != MON_TOP) begin
        since_sof <= since_sof + 1'b1;
      end
    end
  end

  assert_sample_point_R4: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> (seen && since_sof == SAMPLE_C));

  assert_min_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    (sof && !sof_d && seen) |-> (since_sof >= SPACING_C));

endmodule

// File: tb/test_sof_input_latch.sv
module test_sof_input_latch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_a = 1'b0;
  logic        rx_b = 1'b0;
  logic [15:0] din = 16'h0000;
  logic        sof_a, val_a, sof_b, val_b;
  logic [15:0] dout_a, dout_b;

  always #4 clk = ~clk;  // 125 MHz

  // Main instance: delay 2, width 4, sample 8, spacing 44.
  sof_input_latch #(
    .DATA_W(16), .SOF_DELAY(2), .SOF_WIDTH(4), .SAMPLE_AT(8), .SPACING(44)
  ) i_sof_input_latch (
    .clk(clk), .rst(rst), .rx_dv(rx_a), .din(din),
    .sof(sof_a), .dout(dout_a), .dout_valid(val_a)
  );

  // Second instance: spacing shorter than the capture delay (busy lockout visible).
  sof_input_latch #(
    .DATA_W(16), .SOF_DELAY(1), .SOF_WIDTH(3), .SAMPLE_AT(6), .SPACING(4)
  ) i_sof_input_latch_busy (
    .clk(clk), .rst(rst), .rx_dv(rx_b), .din(din),
    .sof(sof_b), .dout(dout_b), .dout_valid(val_b)
  );

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Table: {data, gap from previous accepted rise edge, accepted}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {16'hA5C3, 8'd0,  1'b1},
    {16'h1234, 8'd20, 1'b0},
    {16'h0F0F, 8'd43, 1'b0},
    {16'hBEEF, 8'd44, 1'b1},
    {16'hFFFF, 8'd60, 1'b1},
    {16'h0000, 8'd44, 1'b1},
    {16'h8001, 8'd30, 1'b0},
    {16'h7E57, 8'd45, 1'b1}
  };

  int          last_e0 = 0;
  logic [15:0] prev = 16'h0000;

  // Starts a frame on instance A whose rise edge lands gap edges after last_e0.
  task automatic run_a(input logic [15:0] val, input int gap, input bit acc);
    int e0;
    while (cyc + 1 < last_e0 + gap) @(negedge clk);
    din  = ~val;
    rx_a = 1'b1;
    @(negedge clk);
    e0 = cyc;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk(sof_a == (acc && k >= 2 && k <= 5), acc ? "R2/R3" : "R6",
          "sof timing", sof_a, acc && k >= 2 && k <= 5);
      chk(val_a == (acc && k == 10), acc ? "R5" : "R6",
          "dout_valid timing", val_a, acc && k == 10);
      if (k == 10)
        chk(dout_a == (acc ? val : prev), acc ? "R4" : "R6",
            "captured word", dout_a, acc ? val : prev);
      if (k == 2)  rx_a = 1'b0;
      if (k == 9)  din = val;
      if (k == 10) din = ~val;
    end
    if (acc) begin
      last_e0 = e0;
      prev    = val;
    end
  endtask

  initial begin
    int sof_n, val_n;
    // Reset
    repeat (4) @(negedge clk);
    chk(!sof_a && !val_a && dout_a == 16'h0, "R1", "outputs in reset A", {sof_a, val_a, dout_a}, 0);
    chk(!sof_b && !val_b && dout_b == 16'h0, "R1", "outputs in reset B", {sof_b, val_b, dout_b}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sof_a && !val_a && dout_a == 16'h0, "R1", "outputs after reset", {sof_a, val_a, dout_a}, 0);
    last_e0 = cyc;

    // Vector walk on instance A
    for (int i = 0; i < NV; i++)
      run_a(VEC[i][24:9], int'(VEC[i][8:1]), VEC[i][0]);

    // R8: rx_dv held high for 80 cycles gives one pulse and one capture.
    while (cyc + 1 < last_e0 + 50) @(negedge clk);
    din  = 16'h6C6C;
    rx_a = 1'b1;
    sof_n = 0;
    val_n = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      sof_n += sof_a;
      val_n += val_a;
    end
    chk(sof_n == 4, "R8", "sof cycles while rx_dv held", sof_n, 4);
    chk(val_n == 1, "R8", "captures while rx_dv held", val_n, 1);
    chk(dout_a == 16'h6C6C, "R8", "word while rx_dv held", dout_a, 16'h6C6C);
    rx_a  = 1'b0;
    sof_n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      sof_n += sof_a;
    end
    chk(sof_n == 0, "R8", "sof after rx_dv fall", sof_n, 0);

    // R7 on instance B: delay 1, width 3, sample 6 -> capture 7 edges after rise.
    rx_b = 1'b1;
    @(negedge clk);               // k = 0, edge E0 done
    rx_b = 1'b0;
    for (int k = 1; k <= 18; k++) begin
      bit es, ev;
      @(negedge clk);
      es = (k >= 1 && k <= 3) || (k >= 10 && k <= 12);
      ev = (k == 7) || (k == 16);
      chk(sof_b == es, "R7", "sof with rise on capture edge", sof_b, es);
      chk(val_b == ev, "R7", "dout_valid with rise on capture edge", val_b, ev);
      if (k == 7)  chk(dout_b == 16'h3C3C, "R7", "capture beside ignored rise", dout_b, 16'h3C3C);
      if (k == 16) chk(dout_b == 16'h5A5A, "R7", "capture of next frame", dout_b, 16'h5A5A);
      if (k == 6)  begin rx_b = 1'b1; din = 16'h3C3C; end
      if (k == 7)  begin rx_b = 1'b0; din = 16'hC3C3; end
      if (k == 8)  rx_b = 1'b1;
      if (k == 15) din = 16'h5A5A;
      if (k == 16) din = 16'hA5A5;
    end
    rx_b = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule